// File: doc/BRIEF.md
# Dual-Channel Halfband 2x Interpolator

This block doubles the sample rate of an I/Q transmit stream ahead of a pair of DAC cores. Every second clock cycle it takes one I sample and one Q sample (10-bit two's complement). Every clock cycle it delivers one interpolated sample per channel, so the output rate equals the clock rate. Each channel applies the same 43-tap symmetric halfband lowpass. The first image of the low-rate stream is removed digitally, which leaves the analog reconstruction filter a wider transition band.

The halfband response makes every other coefficient zero except the centre one. That splits each channel into two polyphase branches that both run at half rate. One branch is a delay scaled by the centre coefficient. The other is a 22-tap FIR that adds symmetric tap pairs before it multiplies. A toggling phase enable stands in for a divided clock. On the first half-rate phase the output register loads the delay branch, and on the second it loads the FIR branch. Both branch results are rounded to nearest and saturated to 10 bits.

Top module: `hbi_interp2`

## Requirements
- R1: A synchronous reset clears the delay lines, the pipeline and the phase. While reset is applied, and in the first three cycles after it, both outputs read 0 and `out_valid` is low.
- R2: The phase is 0 in the first cycle after reset and alternates every cycle after that. A sample pair is accepted only in a phase-0 cycle with `in_valid` high. `in_valid` and data in phase-1 cycles have no effect. A phase-0 cycle without `in_valid` leaves the history unchanged, so the next output pair repeats the previous one.
- R3: Let n be the number of samples accepted up to and including phase-0 cycle 2f after reset. The output during cycle 2f+3 is the delay-branch result for n. The output during cycle 2f+4 is the FIR-branch result for n.
- R4: FIR branch for n, with x(i) the sample accepted i positions before the newest (0 if none): acc = sum over j=0..10 of C[j]·(x(j)+x(21−j)). C[0..10] = 42, −67, 118, −202, 329, −512, 776, −1175, 1852, −3332, 10381, signed 16-bit, packed with C[j] at bits [16j+15:16j]. Result = floor((acc+8192)/16384).
- R5: Branch results above 511 are output as 511, and results below −512 as −512.
- R6: The delay branch for n outputs x(11) exactly. The centre coefficient is 16384 with the same rounding as R4.
- R7: The I and Q channels use identical filters and do not affect each other.
- R8: `out_valid` goes high in the third cycle after the first accepted sample and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair present (phase-0 cycles only) |
| i_in | input | 10 | I input sample, two's complement |
| q_in | input | 10 | Q input sample, two's complement |
| i_out | output | 10 | Interpolated I sample |
| q_out | output | 10 | Interpolated Q sample |
| out_valid | output | 1 | Output stream carries filtered data |

## Verification
The bench builds the block with its default parameters: 10-bit samples, 43 taps and the 16-bit default coefficients. At this size a ramp can drive every one of the 1024 input codes through both branches. Full-scale steps and alternating full-scale patterns push the FIR branch past the 10-bit range, so saturation is reached on both rails. Impulses of both polarities expose each coefficient individually. Skipped and stray `in_valid` strobes, together with a reset in mid-stream, are checked against an arithmetic model of the delay-line history.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int HB_DW     = 10;
    localparam int HB_CW     = 16;
    localparam int HB_TAPS   = 43;
    localparam int HB_NBR    = (HB_TAPS + 1) / 2;
    localparam int HB_NPAIR  = HB_NBR / 2;
    localparam int HB_CTR_IDX = HB_NBR / 2;
    localparam int HB_SHIFT  = HB_CW - 2;
    localparam int HB_CENTRE = 1 << HB_SHIFT;

    // pair j sits at bits [16j+15:16j]; j = 0 is the outermost pair
    localparam logic [HB_NPAIR*HB_CW-1:0] HB_COEFS = {
        16'(10381), 16'(-3332), 16'(1852), 16'(-1175), 16'(776), 16'(-512),
        16'(329), 16'(-202), 16'(118), 16'(-67), 16'(42)
    };

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_CALC = 1'b1
    } phase_e;
endpackage

// File: rtl/hbi_phase_gen.sv
module hbi_phase_gen
    import hbi_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output phase_e ph,
    output logic   acc_en,
    output logic   out_valid
);
    typedef struct packed {
        phase_e ph;
        logic   seen;
        logic   st1;
        logic   vld;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ph = (s_q.ph == PH_LOAD) ? PH_CALC : PH_LOAD;
        if (s_q.ph == PH_LOAD) begin
            if (in_valid) s_d.seen = 1'b1;
            if (s_q.st1)  s_d.vld  = 1'b1;
        end else begin
            s_d.st1 = s_q.seen;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ph        = s_q.ph;
    assign acc_en    = (s_q.ph == PH_LOAD) && in_valid;
    assign out_valid = s_q.vld;

    // R2
    ph_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (s_q.ph != $past(s_q.ph)));
    // R8
    vld_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.vld |=> s_q.vld);
endmodule

// File: rtl/hbi_delay_line.sv
module hbi_delay_line #(
    parameter int DW  = 10,
    parameter int NBR = 22
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift_en,
    input  logic [DW-1:0]            din,
    output logic [NBR-1:0][DW-1:0]   taps
);
    typedef struct packed {
        logic [NBR-1:0][DW-1:0] dl;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_en) begin
            s_d.dl[0] = din;
            for (int i = 1; i < NBR; i++) s_d.dl[i] = s_q.dl[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign taps = s_q.dl;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(s_q.dl));
    // R3
    shift_order_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (s_q.dl[NBR-1] == $past(s_q.dl[NBR-2])));
endmodule

// File: rtl/hbi_round_sat.sv
module hbi_round_sat #(
    parameter int IW    = 32,
    parameter int OW    = 10,
    parameter int SHIFT = 14
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam int XW = IW + 1;
    localparam logic signed [XW-1:0] HALF = XW'(1) <<< (SHIFT - 1);
    localparam logic signed [XW-1:0] MAXV = XW'((2 ** (OW - 1)) - 1);
    localparam logic signed [XW-1:0] MINV = XW'(-(2 ** (OW - 1)));

    logic signed [XW-1:0] biased;
    logic signed [XW-1:0] shifted;

    always_comb begin
        biased  = XW'(din) + HALF;
        shifted = biased >>> SHIFT;
        if (shifted > MAXV)      dout = MAXV[OW-1:0];
        else if (shifted < MINV) dout = MINV[OW-1:0];
        else                     dout = shifted[OW-1:0];
    end
endmodule

// File: rtl/hbi_branch_fir.sv
module hbi_branch_fir #(
    parameter int DW    = 10,
    parameter int CW    = 16,
    parameter int NBR   = 22,
    parameter int SHIFT = 14,
    parameter logic [(NBR/2)*CW-1:0] COEFS = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [NBR-1:0][DW-1:0] taps,
    output logic signed [DW-1:0]   y
);
    localparam int NPAIR = NBR / 2;
    localparam int PW    = DW + 1 + CW;
    localparam int AW    = PW + $clog2(NPAIR) + 1;

    typedef struct packed {
        logic [NPAIR-1:0][PW-1:0] prod;
    } st_t;

    st_t s_d, s_q;
    logic signed [PW-1:0] prod_c [NPAIR];
    logic signed [AW-1:0] acc;

    for (genvar j = 0; j < NPAIR; j++) begin : g_pair
        logic signed [DW:0]   pre;
        logic signed [CW-1:0] cf;
        assign cf  = COEFS[j*CW +: CW];
        assign pre = $signed({taps[j][DW-1], taps[j]})
                   + $signed({taps[NBR-1-j][DW-1], taps[NBR-1-j]});
        assign prod_c[j] = PW'(pre) * PW'(cf);
    end

    always_comb begin
        s_d = s_q;
        if (load) begin
            for (int j = 0; j < NPAIR; j++) s_d.prod[j] = prod_c[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        acc = '0;
        for (int j = 0; j < NPAIR; j++) acc = acc + AW'($signed(s_q.prod[j]));
    end

    hbi_round_sat #(.IW(AW), .OW(DW), .SHIFT(SHIFT)) u_rs (
        .din  (acc),
        .dout (y)
    );
endmodule

// File: rtl/hbi_channel.sv
module hbi_channel
    import hbi_pkg::*;
#(
    parameter int DW    = 10,
    parameter int CW    = 16,
    parameter int NBR   = 22,
    parameter int SHIFT = 14,
    parameter int CTRC  = 16384,
    parameter logic [(NBR/2)*CW-1:0] COEFS = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        ph,
    input  logic          acc_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int CTR_IDX = NBR / 2;
    localparam int CPW     = DW + CW;

    typedef struct packed {
        logic [DW-1:0] ctr;
        logic [DW-1:0] hold;
        logic [DW-1:0] out;
    } st_t;

    st_t s_d, s_q;
    logic [NBR-1:0][DW-1:0] taps;
    logic signed [DW-1:0]   a_res;
    logic signed [DW-1:0]   c_res;
    logic signed [CPW-1:0]  cprod;

    hbi_delay_line #(.DW(DW), .NBR(NBR)) u_dl (
        .clk      (clk),
        .rst      (rst),
        .shift_en (acc_en),
        .din      (din),
        .taps     (taps)
    );

    hbi_branch_fir #(.DW(DW), .CW(CW), .NBR(NBR), .SHIFT(SHIFT), .COEFS(COEFS)) u_fir (
        .clk  (clk),
        .rst  (rst),
        .load (ph == PH_CALC),
        .taps (taps),
        .y    (a_res)
    );

    assign cprod = CPW'($signed(s_q.ctr)) * CPW'(CTRC);

    hbi_round_sat #(.IW(CPW), .OW(DW), .SHIFT(SHIFT)) u_crs (
        .din  (cprod),
        .dout (c_res)
    );

    always_comb begin
        s_d = s_q;
        if (ph == PH_CALC) begin
            s_d.ctr = taps[CTR_IDX];
            s_d.out = s_q.hold;
        end else begin
            s_d.out  = c_res;
            s_d.hold = a_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign dout = s_q.out;
endmodule

// File: rtl/hbi_interp2.sv
module hbi_interp2
    import hbi_pkg::*;
#(
    parameter int DW    = HB_DW,
    parameter int CW    = HB_CW,
    parameter int NTAPS = HB_TAPS,
    parameter int CTRC  = HB_CENTRE,
    parameter logic [((NTAPS+1)/4)*CW-1:0] COEFS = HB_COEFS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] i_in,
    input  logic signed [DW-1:0] q_in,
    output logic signed [DW-1:0] i_out,
    output logic signed [DW-1:0] q_out,
    output logic                 out_valid
);
    localparam int NBR   = (NTAPS + 1) / 2;
    localparam int SHIFT = CW - 2;
    localparam int NCH   = 2;

    phase_e        ph;
    logic          acc_en;
    logic [DW-1:0] ch_in  [NCH];
    logic [DW-1:0] ch_out [NCH];

    hbi_phase_gen u_ph (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .ph        (ph),
        .acc_en    (acc_en),
        .out_valid (out_valid)
    );

    assign ch_in[0] = i_in;
    assign ch_in[1] = q_in;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        hbi_channel #(
            .DW(DW), .CW(CW), .NBR(NBR), .SHIFT(SHIFT), .CTRC(CTRC), .COEFS(COEFS)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .ph     (ph),
            .acc_en (acc_en),
            .din    (ch_in[c]),
            .dout   (ch_out[c])
        );
    end

    assign i_out = ch_out[0];
    assign q_out = ch_out[1];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && i_out == '0 && q_out == '0));
endmodule

// File: tb/hbi_interp2_tb_top.sv
`timescale 1ns/1ps
module hbi_interp2_tb_top;
    import hbi_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [HB_DW-1:0] i_in = '0;
    logic signed [HB_DW-1:0] q_in = '0;
    logic signed [HB_DW-1:0] i_out;
    logic signed [HB_DW-1:0] q_out;
    logic out_valid;

    always #2.5 clk = ~clk;

    hbi_interp2 dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .i_in(i_in), .q_in(q_in),
        .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int hist [2][4096];
    int snap [8192];
    int nacc = 0;
    int k = 0;
    bit sat_hit;

    function automatic int coef(int j);
        return int'($signed(HB_COEFS[j*HB_CW +: HB_CW]));
    endfunction

    function automatic int xat(int ch, int n, int i);
        int idx = n - 1 - i;
        return (idx >= 0) ? hist[ch][idx] : 0;
    endfunction

    function automatic int fir_ref(int ch, int n);
        longint acc = 0;
        longint r;
        for (int j = 0; j < HB_NPAIR; j++)
            acc += longint'(coef(j)) * (xat(ch, n, j) + xat(ch, n, HB_NBR - 1 - j));
        r = (acc + 8192) >>> 14;
        sat_hit = (r > 511) || (r < -512);
        if (r > 511) r = 511;
        if (r < -512) r = -512;
        return int'(r);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s k=%0d act=%0d exp=%0d", tag, k, act, exp);
        end
    endtask

    task automatic check_outputs();
        int f;
        int ei, eq;
        if (k < 3) begin
            chk("R1 i_out", int'(i_out), 0);
            chk("R1 q_out", int'(q_out), 0);
            chk("R8 out_valid low", int'(out_valid), 0);
        end else begin
            chk("R8 out_valid high", int'(out_valid), 1);
            if (k % 2 == 1) begin
                f = (k - 3) / 2;
                chk("R3 R6 i delay branch", int'(i_out), xat(0, snap[f], HB_CTR_IDX));
                chk("R3 R6 R7 q delay branch", int'(q_out), xat(1, snap[f], HB_CTR_IDX));
            end else begin
                f = (k - 4) / 2;
                ei = fir_ref(0, snap[f]);
                chk(sat_hit ? "R5 i saturated" : "R4 i fir branch", int'(i_out), ei);
                eq = fir_ref(1, snap[f]);
                chk(sat_hit ? "R5 R7 q saturated" : "R4 R7 q fir branch", int'(q_out), eq);
            end
        end
    endtask

    task automatic tick(bit v, int xi, int xq);
        check_outputs();
        in_valid = v;
        i_in = HB_DW'(xi);
        q_in = HB_DW'(xq);
        if (k % 2 == 0) begin
            if (v) begin
                hist[0][nacc] = xi;
                hist[1][nacc] = xq;
                nacc++;
            end
            snap[k / 2] = nacc;
        end
        @(posedge clk);
        @(negedge clk);
        k++;
    endtask

    function automatic int rnd10();
        return int'($urandom_range(0, 1023)) - 512;
    endfunction

    // one filter cycle: phase-0 slot, then phase-1 slot with optional stray strobe (R2)
    task automatic fcycle(bit v, int xi, int xq, bit junk);
        tick(v, xi, xq);
        if (junk) tick(1'b1, rnd10(), rnd10());
        else      tick(1'b0, 0, 0);
    endtask

    task automatic mid_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset i_out", int'(i_out), 0);
        chk("R1 reset q_out", int'(q_out), 0);
        chk("R1 reset out_valid", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        k = 0;
        nacc = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 idle i_out", int'(i_out), 0);
        chk("R1 idle out_valid", int'(out_valid), 0);
        rst = 1'b0;
        k = 0;
        // R4: impulses of both polarities expose each coefficient
        fcycle(1, 511, -512, 0);
        for (int n = 0; n < 25; n++) fcycle(1, 0, 0, 0);
        fcycle(1, -512, 511, 0);
        for (int n = 0; n < 25; n++) fcycle(1, 0, 0, 0);
        // R5: full-scale steps overshoot the 10-bit range
        for (int n = 0; n < 30; n++) fcycle(1, 511, -512, 0);
        for (int n = 0; n < 30; n++) fcycle(1, -512, 511, 0);
        // R6 R7: every input code, Q carries the complement
        for (int n = -512; n < 512; n++) fcycle(1, n, -1 - n, 0);
        // R5: alternating full scale
        for (int n = 0; n < 30; n++) fcycle(1, (n % 2) ? -512 : 511, (n % 2) ? 511 : -512, 0);
        // R2: skipped strobes and stray phase-1 strobes
        for (int n = 0; n < 40; n++) fcycle(bit'($urandom_range(0, 1)), rnd10(), rnd10(), 1);
        // R1: reset in mid-stream
        mid_reset();
        fcycle(1, rnd10(), rnd10(), 1);
        for (int n = 0; n < 300; n++) fcycle(bit'($urandom_range(0, 3) != 0), rnd10(), rnd10(), bit'($urandom_range(0, 1)));
        for (int n = 0; n < 15; n++) fcycle(1, 0, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired k=%0d act=hung exp=finished", k);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule